// File: doc/BRIEF.md
# Timer interrupt source aggregator

This block gathers four timer events (compare match A, compare match B, counter underflow and counter overflow) into one maskable interrupt request for a CPU interrupt controller. Each event pulse sets its own sticky status bit. A per-source enable register selects which status bits take part in the request. The OR of the enabled status bits is edge-detected: its 0-to-1 transition sets a shared request flag.

The request flag sits in a control register together with a mask bit and two priority bits. The request reaches the CPU only while the flag is set and the mask is clear, and the priority travels with it. An acknowledge from the CPU clears the flag but leaves the status bits alone. Software finds the cause by reading the status register, then clears the bits it has handled by writing 0 to them.

Because the request is edge-triggered, the order of clearing matters. Software should either disable all sources first and then clear, or clear only while every enabled source already reads 0. Otherwise a pending source can be hidden and never raise a new request.

Top module: `tmr_irq_agg`

## Requirements
- R1: After reset, status, enable and control registers read 0, `irq_o` is 0 and `irq_prio_o` is 0.
- R2: A one-cycle pulse on an event input sets its status bit at the next clock edge, whatever the enable bit holds. The status register is at address 0, with bit 0 for compare A, bit 1 for compare B, bit 2 for underflow and bit 3 for overflow. Bits 7:4 read 0.
- R3: A write to address 0 clears each status bit whose data bit is 0 and leaves each bit whose data bit is 1 unchanged. An event pulse in the same cycle as a clear of its bit wins, and the bit stays 1.
- R4: Status bits are never cleared by the acknowledge input.
- R5: The request flag is set at the clock edge after the OR of (status AND enable) goes from 0 to 1. It is not set again while that OR stays 1.
- R6: The control register is at address 2 and its bit 0 is the request flag. The acknowledge input clears the flag, and so does a write with data bit 0 equal to 0. A write with data bit 0 equal to 1 sets the flag. A 0-to-1 transition of the combined condition in the same cycle as a clear wins, and the flag ends up 1.
- R7: Control bit 1 is the mask, bit 2 is priority bit 0 and bit 3 is priority bit 1. `irq_o` is 1 exactly when the flag is 1 and the mask is 0. `irq_prio_o` equals control bits 3:2.
- R8: The enable register is at address 1 with the same bit order as the status register. It reads back the four bits written, and bits 7:4 read 0.
- R9: Setting an enable bit whose status bit is already 1 makes the combined condition rise, and so it raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_cmpa_i | input | 1 | Compare match A event pulse |
| evt_cmpb_i | input | 1 | Compare match B event pulse |
| evt_unf_i | input | 1 | Underflow event pulse |
| evt_ovf_i | input | 1 | Overflow event pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| ack_i | input | 1 | Interrupt accepted by the CPU |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_prio_o | output | 2 | Priority carried with the request |

## Verification
The bench sends an event while its enable is off. A design that gated the status bit with the enable would lose that event. It then applies an acknowledge while the combined condition stays high. A level-sensitive design would raise the request again at once, and a design that cleared status on acknowledge would lose the cause.

Two same-cycle collisions are tested: an event against a software clear of its own bit, and a rising combined condition against an acknowledge. Getting either priority wrong drops an event or a request. The bench also enables a source whose status is already pending, which must raise a request. Finally it toggles the mask and priority bits, so that an inverted mask or swapped priority bits show up on the outputs.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NSRC      = 4;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam int unsigned ADDR_STAT = 0;
  localparam int unsigned ADDR_EN   = 1;
  localparam int unsigned ADDR_CTRL = 2;
  localparam int unsigned CTRL_FLAG = 0;
  localparam int unsigned CTRL_MASK = 1;
  localparam int unsigned CTRL_PR0  = 2;
  localparam int unsigned CTRL_PR1  = 3;
endpackage

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            st_wr_i,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] enable_o,
  output logic            comb_o
);
  logic [NSRC-1:0] status_q, enable_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    // event beats a software clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               status_q[i] <= 1'b0;
      else if (evt_i[i])         status_q[i] <= 1'b1;
      else if (st_wr_i && !wdata_i[i]) status_q[i] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      enable_q[i] <= 1'b0;
      else if (en_wr_i) enable_q[i] <= wdata_i[i];
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign comb_o   = |(status_q & enable_q);
endmodule

// File: rtl/tmr_irq_req.sv
module tmr_irq_req (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       comb_i,
  input  logic       ctrl_wr_i,
  input  logic [3:0] ctrl_wdata_i,
  input  logic       ack_i,
  output logic [3:0] ctrl_o,
  output logic       irq_o,
  output logic [1:0] irq_prio_o
);
  import tmr_irq_pkg::*;

  logic       comb_q, rise;
  logic       flag_q, mask_q;
  logic [1:0] prio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comb_q <= 1'b0;
    else         comb_q <= comb_i;
  end

  assign rise = comb_i & ~comb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (rise)      flag_q <= 1'b1;
    else if (ctrl_wr_i) flag_q <= ctrl_wdata_i[CTRL_FLAG];
    else if (ack_i)     flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      prio_q <= 2'b00;
    end else if (ctrl_wr_i) begin
      mask_q <= ctrl_wdata_i[CTRL_MASK];
      prio_q <= {ctrl_wdata_i[CTRL_PR1], ctrl_wdata_i[CTRL_PR0]};
    end
  end

  assign ctrl_o     = {prio_q, mask_q, flag_q};
  assign irq_o      = flag_q & ~mask_q;
  assign irq_prio_o = prio_q;
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg
  import tmr_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_cmpa_i,
  input  logic          evt_cmpb_i,
  input  logic          evt_unf_i,
  input  logic          evt_ovf_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ack_i,
  output logic          irq_o,
  output logic [1:0]    irq_prio_o
);
  localparam logic [AW-1:0] A_ST = AW'(ADDR_STAT);
  localparam logic [AW-1:0] A_EN = AW'(ADDR_EN);
  localparam logic [AW-1:0] A_CT = AW'(ADDR_CTRL);

  logic [NSRC-1:0] evt_w, status_w, enable_w;
  logic            comb_w;
  logic [3:0]      ctrl_w;

  assign evt_w = {evt_ovf_i, evt_unf_i, evt_cmpb_i, evt_cmpa_i};

  tmr_irq_status #(.NSRC(NSRC)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_w),
    .st_wr_i  (wr_en_i && addr_i == A_ST),
    .en_wr_i  (wr_en_i && addr_i == A_EN),
    .wdata_i  (wdata_i[NSRC-1:0]),
    .status_o (status_w),
    .enable_o (enable_w),
    .comb_o   (comb_w)
  );

  tmr_irq_req u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .comb_i       (comb_w),
    .ctrl_wr_i    (wr_en_i && addr_i == A_CT),
    .ctrl_wdata_i (wdata_i[3:0]),
    .ack_i        (ack_i),
    .ctrl_o       (ctrl_w),
    .irq_o        (irq_o),
    .irq_prio_o   (irq_prio_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_ST:    rdata_o[NSRC-1:0] = status_w;
      A_EN:    rdata_o[NSRC-1:0] = enable_w;
      A_CT:    rdata_o[3:0]      = ctrl_w;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_agg_chk.sv
module tmr_irq_agg_chk #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            ack_i,
  input logic [NSRC-1:0] evt_w,
  input logic [NSRC-1:0] status_w,
  input logic            comb_w,
  input logic            flag_w
);
  logic st_wr, ct_wr;
  assign st_wr = wr_en_i && addr_i == AW'(0);
  assign ct_wr = wr_en_i && addr_i == AW'(2);

  AST_EVT_SETS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |evt_w |=> ((status_w & $past(evt_w)) == $past(evt_w))); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_wr |=> ((status_w & $past(status_w)) == $past(status_w))); // R4

  AST_REQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(comb_w) |=> flag_w); // R5

  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_w && !$rose(comb_w) && !(ct_wr && wdata_i[0])) |=> !flag_w); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !$rose(comb_w) && !ct_wr) |=> !flag_w); // R6
endmodule

bind tmr_irq_agg tmr_irq_agg_chk #(.NSRC(tmr_irq_pkg::NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .ack_i    (ack_i),
  .evt_w    (evt_w),
  .status_w (status_w),
  .comb_w   (comb_w),
  .flag_w   (ctrl_w[0])
);

// File: tb/tmr_irq_agg_test.sv
module tmr_irq_agg_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_cmpa_i = 0, evt_cmpb_i = 0, evt_unf_i = 0, evt_ovf_i = 0;
  logic       wr_en_i = 0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ack_i = 0;
  logic       irq_o;
  logic [1:0] irq_prio_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic [1:0] prio;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tmr_irq_agg uut (.*);

  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic [3:0] evt, input logic ack);
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = d; ack_i = ack;
    {evt_ovf_i, evt_unf_i, evt_cmpb_i, evt_cmpa_i} = evt;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 4'h0, 1'b0);
  endtask

  task automatic chk(input logic [1:0] a, input logic [7:0] rd, input logic irq,
                     input logic [1:0] prio, input string tag);
    exp_t e;
    cyc(1'b0, a, 8'h00, 4'h0, 1'b0);
    e.rd = rd; e.irq = irq; e.prio = prio; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: samples one time unit after the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rdata_o !== e.rd || irq_o !== e.irq || irq_prio_o !== e.prio) begin
          errors++;
          $display("FAIL %s: rdata=%h irq=%b prio=%0d expected rdata=%h irq=%b prio=%0d",
                   e.tag, rdata_o, irq_o, irq_prio_o, e.rd, e.irq, e.prio);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(2'd0, 8'h00, 0, 2'd0, "R1 status");
    chk(2'd1, 8'h00, 0, 2'd0, "R1 enable");
    chk(2'd2, 8'h00, 0, 2'd0, "R1 ctrl");
    // R2 event with enable off
    cyc(0, 2'd0, 8'h00, 4'h2, 0);
    chk(2'd0, 8'h02, 0, 2'd0, "R2 cmpb sets status");
    chk(2'd2, 8'h00, 0, 2'd0, "R5 no request when disabled");
    // R3 write-zero clears, write-one keeps
    cyc(0, 2'd0, 8'h00, 4'h8, 0);
    wr(2'd0, 8'hF7);
    chk(2'd0, 8'h02, 0, 2'd0, "R3 clear ovf keep cmpb");
    cyc(0, 2'd0, 8'h00, 4'h0, 1);
    chk(2'd0, 8'h02, 0, 2'd0, "R4 ack keeps status");
    // R8/R9 enable pending source
    wr(2'd1, 8'hF2);
    chk(2'd1, 8'h02, 0, 2'd0, "R8 enable readback");
    chk(2'd2, 8'h01, 1, 2'd0, "R9 enable pending raises request");
    // R6 ack, R5 no re-request while level stays high
    cyc(0, 2'd0, 8'h00, 4'h0, 1);
    chk(2'd2, 8'h00, 0, 2'd0, "R6 ack clears flag");
    chk(2'd2, 8'h00, 0, 2'd0, "R5 no re-request on steady level");
    // safe clear ordering, new source
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFD);
    chk(2'd0, 8'h00, 0, 2'd0, "R3 cmpb cleared");
    wr(2'd1, 8'h01);
    cyc(0, 2'd0, 8'h00, 4'h1, 0);
    chk(2'd0, 8'h01, 0, 2'd0, "R5 flag not yet set");
    chk(2'd2, 8'h01, 1, 2'd0, "R5 request after rise");
    // R7 mask and priority
    wr(2'd2, 8'h0F);
    chk(2'd2, 8'h0F, 0, 2'd3, "R7 masked");
    wr(2'd2, 8'h0C);
    chk(2'd2, 8'h0C, 0, 2'd3, "R6 write zero clears flag");
    wr(2'd2, 8'h05);
    chk(2'd2, 8'h05, 1, 2'd1, "R7 unmasked prio 1");
    // R3 event wins over clear
    cyc(1, 2'd0, 8'h00, 4'h8, 0);
    chk(2'd0, 8'h08, 1, 2'd1, "R3 event beats clear");
    // R6 rise beats ack
    wr(2'd2, 8'h04);
    chk(2'd2, 8'h04, 0, 2'd1, "R6 flag cleared by write");
    wr(2'd1, 8'h08);
    cyc(0, 2'd0, 8'h00, 4'h0, 1);
    chk(2'd2, 8'h05, 1, 2'd1, "R6 rise beats ack");
    chk(2'd0, 8'h08, 1, 2'd1, "R2 upper status bits zero");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule